// File: doc/BRIEF.md
# Split-Half Interval Timer

This block is an interval timer that counts clock cycles in a 32-bit register made of two 16-bit halves. The halves are linked by a carry/borrow chain, so software sees a single 32-bit counter. A small register interface sets the interval, picks the mode and starts or stops the count. The same interface reads back the live count, a count captured at time-out, and a time-out status flag.

The counter can run in either direction. Counting down, the interval register gives the start value and the counter wraps back to it after reaching zero. Counting up, the interval register gives the terminal value and the counter wraps to zero after matching it. In one-shot mode the timer disables itself at the first time-out. In periodic mode it keeps running. An optional gate holds a started timer until an external trigger arrives. In periodic mode an optional capture holds the count seen at the last time-out. Every time-out produces a one-cycle pulse and sets a sticky flag that drives an interrupt line.

Register offsets on `reg_addr`:
- 0: run bit in bit 0. Hardware clears it on a one-shot time-out.
- 1: mode. Bit 0 selects periodic (1) or one-shot (0). Bit 1 selects up (1) or down (0). Bit 2 waits for the trigger. Bit 3 enables capture.
- 2: full 32-bit interval.
- 3: count view. This is the captured value when periodic capture is on, otherwise the live count.
- 4: live count.
- 5: flag in bit 0, cleared by writing 1.
- 6: write-only upper 16 bits of the interval, taken from `reg_wdata[15:0]`.
- 7: upper 16 bits of the count view, returned in bits 15:0.

Top module: `ivtimer`

## Requirements
- R1: After reset all registers read 0, and `irq` and `timeout_pulse` are low.
- R2: Counting down, the counter steps down by 1 each cycle. At 0 it asserts `timeout_pulse` for one cycle and reloads the interval on the next edge. The period is interval+1 cycles.
- R3: Counting up, the counter steps up by 1 each cycle. On matching the interval it pulses and restarts from 0 on the next edge.
- R4: In one-shot mode a time-out clears the run bit (offset 0 reads 0). The counter then holds its reload value with no further pulses.
- R5: In periodic mode the run bit stays set and counting continues after a time-out.
- R6: With the trigger gate on, a set run bit does not count until `trig_in` is seen high on a clock edge. Counting begins one cycle after that. Once counting has started, the trigger is ignored. After the run bit is cleared and set again, the timer waits for a new trigger.
- R7: With periodic mode and capture on, offset 3 holds the count present at the last time-out while offset 4 keeps moving.
- R8: With capture off, offset 3 reads the same live count as offset 4.
- R9: A 32-bit interval write loads both halves, with bits 31:16 going to the upper half. A write to offset 6 changes only bits 31:16. Offset 7 returns the upper half of the count. A borrow passes from the lower half into the upper half.
- R10: Each time-out sets the flag and raises `irq`. Writing 1 to bit 0 of offset 5 clears both. A new time-out wins over a clear in the same cycle.
- R11: Clearing the run bit freezes the counter. Setting it again resumes counting from the frozen value.
- R12: While stopped, writing the interval or the mode sets the counter to the start value: 0 when counting up, the interval when counting down. While running, a new interval takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from state) |
| trig_in | input | 1 | Start trigger, sampled on the clock |
| timeout_pulse | output | 1 | One-cycle pulse per time-out |
| irq | output | 1 | High while the time-out flag is set |

## Verification
The bench times each time-out to the exact edge in both directions. An off-by-one terminal test would show up as a period of interval or interval+2, and a wrong reload would show up as a wrong count after the wrap. It checks the disable edge itself, since the counter still steps on the edge where the run bit is written to 0. It also checks that re-enabling does not restart the count. The trigger test shows that a timer which only sampled the gate once, or kept the old start across a disable, would count when it should wait. The half-word tests catch a lost borrow between halves and an upper-half write that disturbs the lower half. The capture test uses an up-count, so a stale or live value would read differently from the captured interval.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 3'd0,
        A_MODE    = 3'd1,
        A_LOAD    = 3'd2,
        A_COUNT   = 3'd3,
        A_VALUE   = 3'd4,
        A_STAT    = 3'd5,
        A_LOADHI  = 3'd6,
        A_COUNTHI = 3'd7
    } addr_e;

    // bit 3 capture, bit 2 trigger gate, bit 1 up, bit 0 periodic
    typedef struct packed {
        logic snap;
        logic wot;
        logic up;
        logic periodic;
    } mode_t;

endpackage

// File: rtl/ivt_half.sv
// One counter half: steps when carry-in is high, reports carry/borrow out.
module ivt_half #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] val,
    input  logic         up,
    input  logic         cin,
    output logic [W-1:0] nxt,
    output logic         cout
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        cout = cin && (up ? (val == '1) : (val == '0));
        if (!cin)
            nxt = val;
        else if (up)
            nxt = val + ONE;
        else
            nxt = val - ONE;
    end
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
    import ivt_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned CNT_W  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [3:0]        mode,
    input  logic [CNT_W-1:0]  load,
    input  logic [CNT_W-1:0]  view,
    input  logic [CNT_W-1:0]  value,
    input  logic              flag,
    output logic [CNT_W-1:0]  rdata
);
    always_comb begin
        unique case (addr_e'(addr))
            A_CTRL:    rdata = CNT_W'(en);
            A_MODE:    rdata = CNT_W'(mode);
            A_LOAD:    rdata = load;
            A_COUNT:   rdata = view;
            A_VALUE:   rdata = value;
            A_STAT:    rdata = CNT_W'(flag);
            A_LOADHI:  rdata = CNT_W'(load[CNT_W-1 -: HALF_W]);
            A_COUNTHI: rdata = CNT_W'(view[CNT_W-1 -: HALF_W]);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivt_pkg::*;
#(
    parameter  int unsigned HALF_W     = 16,
    parameter  int unsigned NUM_HALVES = 2,
    localparam int unsigned CNT_W      = HALF_W * NUM_HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              trig_in,
    output logic              timeout_pulse,
    output logic              irq
);
    typedef struct packed {
        logic             en;
        logic             started;
        logic             trig_s;
        mode_t            mode;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             flag;
        logic             pulse;
    } state_t;

    state_t s_d, s_q;

    addr_e            addr;
    logic             go;
    logic             tout;
    logic             init;
    logic [NUM_HALVES:0] carry;
    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] count_view;

    assign addr = addr_e'(reg_addr);

    // counting is allowed when running and either ungated, already started,
    // or the registered trigger is high this cycle
    assign go = s_q.en && (!s_q.mode.wot || s_q.started || s_q.trig_s);

    assign carry[0] = go;
    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        ivt_half #(.W(HALF_W)) u_half (
            .val  (s_q.cnt[g*HALF_W +: HALF_W]),
            .up   (s_q.mode.up),
            .cin  (carry[g]),
            .nxt  (stepped[g*HALF_W +: HALF_W]),
            .cout (carry[g+1])
        );
    end

    // down: borrow out of the top half means the count sat at zero
    assign tout = s_q.mode.up ? (go && (s_q.cnt == s_q.load)) : carry[NUM_HALVES];

    assign init = reg_wr && !s_q.en &&
                  (addr == A_MODE || addr == A_LOAD || addr == A_LOADHI);

    always_comb begin
        s_d        = s_q;
        s_d.pulse  = 1'b0;
        s_d.trig_s = trig_in;

        if (go)
            s_d.cnt = stepped;

        if (tout) begin
            s_d.cnt   = s_q.mode.up ? '0 : s_q.load;
            s_d.pulse = 1'b1;
            if (!s_q.mode.periodic)
                s_d.en = 1'b0;
            else if (s_q.mode.snap)
                s_d.snap = s_q.cnt;
        end

        if (reg_wr && addr == A_STAT && reg_wdata[0])
            s_d.flag = 1'b0;
        if (tout)
            s_d.flag = 1'b1;

        if (reg_wr) begin
            unique case (addr)
                A_CTRL:   s_d.en   = reg_wdata[0];
                A_MODE:   s_d.mode = mode_t'(reg_wdata[3:0]);
                A_LOAD:   s_d.load = reg_wdata;
                A_LOADHI: s_d.load[CNT_W-1 -: HALF_W] = reg_wdata[HALF_W-1:0];
                default: ;
            endcase
        end

        if (init)
            s_d.cnt = s_d.mode.up ? '0 : s_d.load;

        s_d.started = s_d.en && s_q.en &&
                      (s_q.started || (s_q.mode.wot && s_q.trig_s));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign count_view    = (s_q.mode.periodic && s_q.mode.snap) ? s_q.snap : s_q.cnt;
    assign timeout_pulse = s_q.pulse;
    assign irq           = s_q.flag;

    ivt_rdmux #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_rdmux (
        .addr  (reg_addr),
        .en    (s_q.en),
        .mode  (s_q.mode),
        .load  (s_q.load),
        .view  (count_view),
        .value (s_q.cnt),
        .flag  (s_q.flag),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             timeout_pulse,
    input logic             irq,
    input logic             en,
    input logic             started,
    input logic             trig_s,
    input logic             go,
    input logic [3:0]       mode,
    input logic [CNT_W-1:0] cnt
);
    a_r10_irq_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> irq);

    a_r4_oneshot_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse && !mode[0] && !$past(reg_wr) |-> !en);

    a_r3_up_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse && mode[1] && !$past(reg_wr) |-> cnt == '0);

    a_r11_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) && !$past(reg_wr) |-> $stable(cnt));

    a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(go) && !$past(mode[1]) && ($past(cnt) != '0) && !$past(reg_wr)
        |-> cnt == $past(cnt) - CNT_W'(1));

    a_r6_hold_for_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode[2] && !started && !trig_s && !reg_wr |=> $stable(cnt));
endmodule

bind ivtimer ivtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .timeout_pulse (timeout_pulse),
    .irq           (irq),
    .en            (s_q.en),
    .started       (s_q.started),
    .trig_s        (s_q.trig_s),
    .go            (go),
    .mode          (s_q.mode),
    .cnt           (s_q.cnt)
);

// File: tb/ivtimer_test.sv
module ivtimer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trig_in = 1'b0;
    logic        timeout_pulse;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [2:0] O_CTRL = 3'd0, O_MODE = 3'd1, O_LOAD = 3'd2, O_COUNT = 3'd3,
                           O_VALUE = 3'd4, O_STAT = 3'd5, O_LOADHI = 3'd6, O_COUNTHI = 3'd7;

    always #10 clk = ~clk;

    ivtimer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .timeout_pulse(timeout_pulse), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // called just after a falling edge; the next rising edge commits
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) chk_reg("R1 register zero", 3'(a), 32'h0);
        chk("R1 irq low", {31'b0, irq}, 32'h0);
        chk("R1 pulse low", {31'b0, timeout_pulse}, 32'h0);
    endtask

    task automatic t_down_periodic;
        wr(O_MODE, 32'h1);
        wr(O_LOAD, 32'd3);
        chk_reg("R12 down init from interval", O_COUNT, 32'd3);
        wr(O_CTRL, 32'h1);
        for (int k = 1; k <= 3; k++) begin
            step(1);
            chk_reg("R2 down step", O_VALUE, 32'(3 - k));
            chk_reg("R8 view equals live", O_COUNT, 32'(3 - k));
            chk("R2 no early pulse", {31'b0, timeout_pulse}, 32'h0);
        end
        step(1);
        chk("R2 pulse at zero+1", {31'b0, timeout_pulse}, 32'h1);
        chk_reg("R2 reload", O_VALUE, 32'd3);
        chk("R10 irq set", {31'b0, irq}, 32'h1);
        step(1);
        chk("R2 pulse one cycle", {31'b0, timeout_pulse}, 32'h0);
        chk_reg("R5 still running", O_CTRL, 32'h1);
        chk_reg("R5 keeps counting", O_VALUE, 32'd2);
        wr(O_CTRL, 32'h0);
        wr(O_STAT, 32'h1);
        chk("R10 irq cleared", {31'b0, irq}, 32'h0);
        chk_reg("R10 flag cleared", O_STAT, 32'h0);
    endtask

    task automatic t_up_oneshot;
        wr(O_MODE, 32'h2);
        wr(O_LOAD, 32'd2);
        chk_reg("R12 up init zero", O_VALUE, 32'd0);
        wr(O_CTRL, 32'h1);
        step(1); chk_reg("R3 up step", O_VALUE, 32'd1);
        step(1); chk_reg("R3 up at interval", O_VALUE, 32'd2);
        step(1);
        chk("R3 pulse", {31'b0, timeout_pulse}, 32'h1);
        chk_reg("R3 restart zero", O_VALUE, 32'd0);
        chk_reg("R4 run bit cleared", O_CTRL, 32'h0);
        step(3);
        chk_reg("R4 held after one-shot", O_VALUE, 32'd0);
        chk("R4 no second pulse", {31'b0, timeout_pulse}, 32'h0);
    endtask

    task automatic t_freeze;
        wr(O_MODE, 32'h1);
        wr(O_LOAD, 32'd100);
        wr(O_CTRL, 32'h1);
        step(5);
        chk_reg("R2 count after 5", O_VALUE, 32'd95);
        wr(O_CTRL, 32'h0);
        chk_reg("R11 last step on disable edge", O_VALUE, 32'd94);
        step(4);
        chk_reg("R11 frozen", O_VALUE, 32'd94);
        wr(O_CTRL, 32'h1);
        chk_reg("R11 no restart", O_VALUE, 32'd94);
        step(1);
        chk_reg("R11 resumes", O_VALUE, 32'd93);
        wr(O_CTRL, 32'h0);
    endtask

    task automatic t_reload_running;
        wr(O_LOAD, 32'd4);
        wr(O_CTRL, 32'h1);
        step(1);
        wr(O_LOAD, 32'd10);
        chk_reg("R12 running write no init", O_VALUE, 32'd2);
        chk_reg("R12 interval stored", O_LOAD, 32'd10);
        step(2);
        chk_reg("R12 reaches zero", O_VALUE, 32'd0);
        step(1);
        chk("R12 pulse", {31'b0, timeout_pulse}, 32'h1);
        chk_reg("R12 new interval at reload", O_VALUE, 32'd10);
        wr(O_CTRL, 32'h0);
    endtask

    task automatic t_trigger;
        wr(O_MODE, 32'h5);
        wr(O_LOAD, 32'd6);
        wr(O_CTRL, 32'h1);
        step(3);
        chk_reg("R6 waits for trigger", O_VALUE, 32'd6);
        trig_in = 1'b1;
        step(1);
        trig_in = 1'b0;
        chk_reg("R6 trigger just sampled", O_VALUE, 32'd6);
        step(1);
        chk_reg("R6 starts after trigger", O_VALUE, 32'd5);
        step(1);
        chk_reg("R6 continues without trigger", O_VALUE, 32'd4);
        wr(O_CTRL, 32'h0);
        chk_reg("R11 stop edge", O_VALUE, 32'd3);
        wr(O_CTRL, 32'h1);
        step(3);
        chk_reg("R6 waits again after re-enable", O_VALUE, 32'd3);
        trig_in = 1'b1;
        step(1);
        trig_in = 1'b0;
        step(1);
        chk_reg("R6 second trigger starts", O_VALUE, 32'd2);
        wr(O_CTRL, 32'h0);
    endtask

    task automatic t_snapshot;
        wr(O_MODE, 32'hB);
        wr(O_LOAD, 32'd3);
        wr(O_CTRL, 32'h1);
        step(3);
        chk_reg("R3 up reaches interval", O_VALUE, 32'd3);
        step(1);
        chk_reg("R7 capture holds", O_COUNT, 32'd3);
        chk_reg("R7 live wrapped", O_VALUE, 32'd0);
        step(2);
        chk_reg("R7 capture steady", O_COUNT, 32'd3);
        chk_reg("R7 live moves", O_VALUE, 32'd2);
        wr(O_CTRL, 32'h0);
        wr(O_MODE, 32'h3);
        wr(O_CTRL, 32'h1);
        step(2);
        chk_reg("R8 view live", O_COUNT, 32'd2);
        chk_reg("R8 value live", O_VALUE, 32'd2);
        wr(O_CTRL, 32'h0);
    endtask

    task automatic t_halves;
        wr(O_MODE, 32'h1);
        wr(O_LOAD, 32'h0001_0001);
        chk_reg("R9 full write", O_VALUE, 32'h0001_0001);
        chk_reg("R9 upper half read", O_COUNTHI, 32'h0000_0001);
        wr(O_LOADHI, 32'hFFFF_0002);
        chk_reg("R9 upper-only write", O_LOAD, 32'h0002_0001);
        wr(O_LOAD, 32'h0001_0001);
        wr(O_CTRL, 32'h1);
        step(1);
        chk_reg("R9 low to zero", O_VALUE, 32'h0001_0000);
        step(1);
        chk_reg("R9 borrow across halves", O_VALUE, 32'h0000_FFFF);
        chk_reg("R9 upper half after borrow", O_COUNTHI, 32'h0);
        wr(O_CTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_down_periodic;
        t_up_oneshot;
        t_freeze;
        t_reload_running;
        t_trigger;
        t_snapshot;
        t_halves;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule